// File: doc/BRIEF.md
# Exception Entry Sequencer

This block works out, in one clock, what the processor's control registers and program counter become when a trap or interrupt is taken. The pipeline raises a one-cycle take strobe together with a 5-bit cause code. It also supplies the current PC, the live status, tlbmisc and exception register values, the address of a faulting access, and two configured handler addresses: a general vector and a fast vector for first-level TLB misses. On the edge where the strobe is high, the block registers the new status, exception, tlbmisc and PC values.

The block also holds the save registers that only exception entry writes: the saved status for exceptions, the saved status for breaks, the two return addresses and the bad-address register. A one-cycle `done_o` pulse follows each accepted entry. The pipeline copies the registered results into its architectural state on that pulse. A code outside the known set raises `err_o` and changes nothing.

The exception-handler flag (EH) in the incoming status decides which path a fault takes. A TLB miss with EH clear is a first-level miss. It saves state and goes to the fast vector. A TLB miss with EH already set is a nested miss. It keeps the first handler's saved state, marks a double miss and goes to the general vector.

Top module: `exc_entry_seq`

## Requirements
- R1: A cause of 2 (interrupt) with status bit 0 (PIE) set copies status into estatus and writes PC+4 to ea. Status becomes the old value with bit 3 (IH) set and bits 0 (PIE) and 1 (user mode) cleared. The PC becomes the general vector.
- R2: An interrupt request while status bit 0 is clear is ignored. No `done_o`, no `err_o`, and every output keeps its value.
- R3: Every accepted cause except 6 sets exception bits [6:2] to the cause code and keeps every other bit of the incoming exception value.
- R4: A cause of 12 (TLB miss) with status bit 2 (EH) clear does the following. It copies status into estatus and writes PC+4 to ea. Status gets EH set and bits 0 and 1 cleared. In tlbmisc, bit 0 (double miss) is cleared and bit 1 (write flag) is set. The PC becomes the fast TLB-miss vector.
- R5: A cause of 12 with EH set leaves estatus and ea unchanged. Status gets EH set and bits 0 and 1 cleared. Tlbmisc bit 0 is set. The PC becomes the general vector.
- R6: Causes 14, 15 and 16 (execute, read and write permission faults) always copy status into estatus and write PC+4 to ea. Status gets EH set and bits 0 and 1 cleared. Tlbmisc passes through unchanged. The PC becomes the general vector.
- R7: Causes 3, 5, 9, 10 and 11 (trap, illegal instruction, supervisor-only faults) write estatus and ea only when EH was clear. In both cases status gets EH set and bits 0 and 1 cleared, and the PC becomes the general vector.
- R8: Cause 7 (break) writes status to bstatus and PC+4 to ba only when EH was clear, and never touches estatus or ea. Status gets EH set and bits 0 and 1 cleared. The PC becomes the general vector.
- R9: Cause 6 (unaligned access) loads the fault address into badaddr and sets the exception value to 6 shifted left by two, with every other bit zero. Status and tlbmisc pass through unchanged, estatus and ea are kept, and the PC becomes the general vector.
- R10: A take strobe whose code is not in the set {2,3,5,6,7,9,10,11,12,14,15,16} gives a one-cycle `err_o` pulse one edge later. There is no `done_o` and no output changes.
- R11: Results appear on the clock edge that samples the strobe, with a single-cycle `done_o`. Without a strobe, every output holds even when the inputs change.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception take strobe |
| cause_i | input | 5 | Cause code |
| pc_i | input | DW | PC of the faulting instruction |
| status_i | input | DW | Current status register |
| tlbmisc_i | input | DW | Current tlbmisc register |
| exc_i | input | DW | Current exception register |
| fault_addr_i | input | DW | Address of the faulting access |
| vec_gen_i | input | DW | General exception vector |
| vec_tlb_i | input | DW | Fast TLB-miss vector |
| status_o | output | DW | New status |
| estatus_o | output | DW | Saved status for exceptions |
| bstatus_o | output | DW | Saved status for breaks |
| exc_o | output | DW | New exception register |
| tlbmisc_o | output | DW | New tlbmisc |
| ea_o | output | DW | Exception return address |
| ba_o | output | DW | Break return address |
| badaddr_o | output | DW | Faulting address |
| pc_o | output | DW | Handler address |
| done_o | output | 1 | Entry committed (one cycle) |
| err_o | output | 1 | Unknown cause rejected (one cycle) |

## Verification
Each class of cause produces its own pattern across the outputs. A mis-decoded cause or a wrong EH reading therefore shows at the next edge, as a wrong handler address, an unexpected write to a save register or a wrong tlbmisc bit. The worst errors are silent overwrites of estatus, ea, bstatus or ba on a nested entry. Those only show when a later entry is compared against the values saved earlier, so the tests chain first-level and nested entries and check the saved registers after each step. A masked interrupt or an unknown code that changes any state shows at once, as a moved output or a stray pulse.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CW = 5;

   localparam logic [CW-1:0] CAUSE_IRQ     = 5'd2;
   localparam logic [CW-1:0] CAUSE_TRAP    = 5'd3;
   localparam logic [CW-1:0] CAUSE_ILLEGAL = 5'd5;
   localparam logic [CW-1:0] CAUSE_UNALIGN = 5'd6;
   localparam logic [CW-1:0] CAUSE_BREAK   = 5'd7;
   localparam logic [CW-1:0] CAUSE_SUPERI  = 5'd9;
   localparam logic [CW-1:0] CAUSE_SUPERA  = 5'd10;
   localparam logic [CW-1:0] CAUSE_SUPERD  = 5'd11;
   localparam logic [CW-1:0] CAUSE_TLBMISS = 5'd12;
   localparam logic [CW-1:0] CAUSE_TLBX    = 5'd14;
   localparam logic [CW-1:0] CAUSE_TLBR    = 5'd15;
   localparam logic [CW-1:0] CAUSE_TLBW    = 5'd16;

   typedef enum logic [2:0] {
      K_NONE, K_IRQ, K_MISS, K_PERM, K_SOFT, K_BRK, K_ALIGN
   } kind_e;

   function automatic kind_e classify(input logic [CW-1:0] c);
      case (c)
         CAUSE_IRQ:                                 return K_IRQ;
         CAUSE_TLBMISS:                             return K_MISS;
         CAUSE_TLBX, CAUSE_TLBR, CAUSE_TLBW:        return K_PERM;
         CAUSE_TRAP, CAUSE_ILLEGAL,
         CAUSE_SUPERI, CAUSE_SUPERA, CAUSE_SUPERD:  return K_SOFT;
         CAUSE_BREAK:                               return K_BRK;
         CAUSE_UNALIGN:                             return K_ALIGN;
         default:                                   return K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/exc_decode.sv
module exc_decode
   import exc_pkg::*;
(
   input  logic [CW-1:0] cause_i,
   output kind_e         kind_o,
   output logic          known_o
);
   always_comb begin
      kind_o  = classify(cause_i);
      known_o = (kind_o != K_NONE);
   end
endmodule

// File: rtl/exc_nextstate.sv
module exc_nextstate
   import exc_pkg::*;
#(
   parameter int DW           = 32,
   parameter int ST_PIE       = 0,
   parameter int ST_U         = 1,
   parameter int ST_EH        = 2,
   parameter int ST_IH        = 3,
   parameter int TM_DBL       = 0,
   parameter int TM_WR        = 1,
   parameter bit USE_FAST_VEC = 1'b1
) (
   input  kind_e          kind_i,
   input  logic [CW-1:0]  cause_i,
   input  logic [DW-1:0]  pc_i,
   input  logic [DW-1:0]  status_i,
   input  logic [DW-1:0]  tlbmisc_i,
   input  logic [DW-1:0]  exc_i,
   input  logic [DW-1:0]  vec_gen_i,
   input  logic [DW-1:0]  vec_tlb_i,
   output logic [DW-1:0]  status_n_o,
   output logic [DW-1:0]  tlbmisc_n_o,
   output logic [DW-1:0]  exc_n_o,
   output logic [DW-1:0]  pc_n_o,
   output logic [DW-1:0]  ret_o,
   output logic           we_exc_save_o,
   output logic           we_brk_save_o,
   output logic           we_bad_o
);
   localparam logic [DW-1:0] PC_STEP    = DW'(4);
   localparam logic [DW-1:0] FIELD_MASK = DW'(7'h7C);

   logic [DW-1:0] miss_vec;
   logic [DW-1:0] cause_fld;
   logic [DW-1:0] masked;
   logic          eh;

   generate
      if (USE_FAST_VEC) begin : g_fast
         assign miss_vec = vec_tlb_i;
      end else begin : g_slow
         assign miss_vec = vec_gen_i;
      end
   endgenerate

   always_comb begin
      eh        = status_i[ST_EH];
      cause_fld = DW'(cause_i) << 2;
      masked    = status_i;
      masked[ST_PIE] = 1'b0;
      masked[ST_U]   = 1'b0;

      status_n_o    = status_i;
      tlbmisc_n_o   = tlbmisc_i;
      exc_n_o       = (exc_i & ~FIELD_MASK) | cause_fld;
      pc_n_o        = vec_gen_i;
      ret_o         = pc_i + PC_STEP;
      we_exc_save_o = 1'b0;
      we_brk_save_o = 1'b0;
      we_bad_o      = 1'b0;

      case (kind_i)
         K_IRQ: begin
            status_n_o        = masked;
            status_n_o[ST_IH] = 1'b1;
            we_exc_save_o     = 1'b1;
         end
         K_MISS: begin
            status_n_o        = masked;
            status_n_o[ST_EH] = 1'b1;
            if (!eh) begin
               we_exc_save_o       = 1'b1;
               tlbmisc_n_o[TM_DBL] = 1'b0;
               tlbmisc_n_o[TM_WR]  = 1'b1;
               pc_n_o              = miss_vec;
            end else begin
               tlbmisc_n_o[TM_DBL] = 1'b1;
            end
         end
         K_PERM: begin
            status_n_o        = masked;
            status_n_o[ST_EH] = 1'b1;
            we_exc_save_o     = 1'b1;
         end
         K_SOFT: begin
            status_n_o        = masked;
            status_n_o[ST_EH] = 1'b1;
            we_exc_save_o     = !eh;
         end
         K_BRK: begin
            status_n_o        = masked;
            status_n_o[ST_EH] = 1'b1;
            we_brk_save_o     = !eh;
         end
         K_ALIGN: begin
            exc_n_o  = cause_fld;
            we_bad_o = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_pkg::*;
#(
   parameter int DW           = 32,
   parameter int ST_PIE       = 0,
   parameter int ST_U         = 1,
   parameter int ST_EH        = 2,
   parameter int ST_IH        = 3,
   parameter int TM_DBL       = 0,
   parameter int TM_WR        = 1,
   parameter bit USE_FAST_VEC = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           take_i,
   input  logic [4:0]     cause_i,
   input  logic [DW-1:0]  pc_i,
   input  logic [DW-1:0]  status_i,
   input  logic [DW-1:0]  tlbmisc_i,
   input  logic [DW-1:0]  exc_i,
   input  logic [DW-1:0]  fault_addr_i,
   input  logic [DW-1:0]  vec_gen_i,
   input  logic [DW-1:0]  vec_tlb_i,
   output logic [DW-1:0]  status_o,
   output logic [DW-1:0]  estatus_o,
   output logic [DW-1:0]  bstatus_o,
   output logic [DW-1:0]  exc_o,
   output logic [DW-1:0]  tlbmisc_o,
   output logic [DW-1:0]  ea_o,
   output logic [DW-1:0]  ba_o,
   output logic [DW-1:0]  badaddr_o,
   output logic [DW-1:0]  pc_o,
   output logic           done_o,
   output logic           err_o
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("exc_entry_seq: DW must be at least 8");
      end
      if (ST_PIE >= DW || ST_U >= DW || ST_EH >= DW || ST_IH >= DW) begin : g_bad_st
         $error("exc_entry_seq: status bit position outside DW");
      end
      if (ST_PIE == ST_U || ST_PIE == ST_EH || ST_PIE == ST_IH ||
          ST_U == ST_EH || ST_U == ST_IH || ST_EH == ST_IH) begin : g_dup_st
         $error("exc_entry_seq: status bit positions must differ");
      end
      if (TM_DBL >= DW || TM_WR >= DW || TM_DBL == TM_WR) begin : g_bad_tm
         $error("exc_entry_seq: tlbmisc bit positions invalid");
      end
   endgenerate

   kind_e         kind;
   logic          known;
   logic [DW-1:0] status_n, tlbmisc_n, exc_n, pc_n, ret;
   logic          we_es, we_bs, we_bad;
   logic          accept, reject;

   exc_decode u_dec (
      .cause_i (cause_i),
      .kind_o  (kind),
      .known_o (known)
   );

   exc_nextstate #(
      .DW(DW), .ST_PIE(ST_PIE), .ST_U(ST_U), .ST_EH(ST_EH), .ST_IH(ST_IH),
      .TM_DBL(TM_DBL), .TM_WR(TM_WR), .USE_FAST_VEC(USE_FAST_VEC)
   ) u_ns (
      .kind_i        (kind),
      .cause_i       (cause_i),
      .pc_i          (pc_i),
      .status_i      (status_i),
      .tlbmisc_i     (tlbmisc_i),
      .exc_i         (exc_i),
      .vec_gen_i     (vec_gen_i),
      .vec_tlb_i     (vec_tlb_i),
      .status_n_o    (status_n),
      .tlbmisc_n_o   (tlbmisc_n),
      .exc_n_o       (exc_n),
      .pc_n_o        (pc_n),
      .ret_o         (ret),
      .we_exc_save_o (we_es),
      .we_brk_save_o (we_bs),
      .we_bad_o      (we_bad)
   );

   always_comb begin
      accept = take_i && known && !(kind == K_IRQ && !status_i[ST_PIE]);
      reject = take_i && !known;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         status_o  <= '0;
         estatus_o <= '0;
         bstatus_o <= '0;
         exc_o     <= '0;
         tlbmisc_o <= '0;
         ea_o      <= '0;
         ba_o      <= '0;
         badaddr_o <= '0;
         pc_o      <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         done_o <= accept;
         err_o  <= reject;
         if (accept) begin
            status_o  <= status_n;
            exc_o     <= exc_n;
            tlbmisc_o <= tlbmisc_n;
            pc_o      <= pc_n;
            if (we_es) begin
               estatus_o <= status_i;
               ea_o      <= ret;
            end
            if (we_bs) begin
               bstatus_o <= status_i;
               ba_o      <= ret;
            end
            if (we_bad) badaddr_o <= fault_addr_i;
         end
      end
   end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ST_PIE = 0,
   parameter int ST_U   = 1,
   parameter int ST_EH  = 2
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           take_i,
   input logic [4:0]     cause_i,
   input logic [DW-1:0]  status_i,
   input logic [DW-1:0]  vec_gen_i,
   input logic [DW-1:0]  vec_tlb_i,
   input logic [DW-1:0]  status_o,
   input logic [DW-1:0]  estatus_o,
   input logic [DW-1:0]  exc_o,
   input logic [DW-1:0]  ea_o,
   input logic [DW-1:0]  pc_o,
   input logic           done_o,
   input logic           err_o
);
   AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> !done_o);                                                   // R10

   AST_CAUSE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> exc_o[6:2] == $past(cause_i));                             // R3

   AST_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (pc_o == $past(vec_gen_i) || pc_o == $past(vec_tlb_i)));   // R4

   AST_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(take_i) && $past(cause_i) == CAUSE_IRQ && !$past(status_i[ST_PIE]))
      |-> (!done_o && !err_o));                                             // R2

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(take_i) |-> ($stable(estatus_o) && $stable(ea_o) && $stable(pc_o)
                          && !done_o && !err_o));                           // R11

   AST_PRIV_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && $past(cause_i) != CAUSE_UNALIGN)
      |-> (!status_o[ST_PIE] && !status_o[ST_U]));                          // R1

   AST_EH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && $past(cause_i) != CAUSE_UNALIGN && $past(cause_i) != CAUSE_IRQ)
      |-> status_o[ST_EH]);                                                 // R7
endmodule

bind exc_entry_seq exc_entry_chk #(
   .DW(DW), .ST_PIE(ST_PIE), .ST_U(ST_U), .ST_EH(ST_EH)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .take_i    (take_i),
   .cause_i   (cause_i),
   .status_i  (status_i),
   .vec_gen_i (vec_gen_i),
   .vec_tlb_i (vec_tlb_i),
   .status_o  (status_o),
   .estatus_o (estatus_o),
   .exc_o     (exc_o),
   .ea_o      (ea_o),
   .pc_o      (pc_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
   localparam logic [31:0] VGEN = 32'h0000_0120;
   localparam logic [31:0] VTLB = 32'h0000_0400;
   localparam logic [31:0] FMSK = 32'h0000_007C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take = 1'b0;
   logic [4:0]  cause = '0;
   logic [31:0] pc = '0, st = '0, tm = '0, ex = '0, fa = '0;
   logic [31:0] status_o, estatus_o, bstatus_o, exc_o, tlbmisc_o;
   logic [31:0] ea_o, ba_o, badaddr_o, pc_o;
   logic        done_o, err_o;

   int n_chk = 0;
   int n_bad = 0;

   // model of the expected outputs
   logic [31:0] m_st, m_est, m_bst, m_ex, m_tm, m_ea, m_ba, m_bad, m_pc;

   always #4 clk = ~clk;

   exc_entry_seq u0 (
      .clk_i(clk), .rst_ni(rst_n), .take_i(take), .cause_i(cause),
      .pc_i(pc), .status_i(st), .tlbmisc_i(tm), .exc_i(ex),
      .fault_addr_i(fa), .vec_gen_i(VGEN), .vec_tlb_i(VTLB),
      .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
      .exc_o(exc_o), .tlbmisc_o(tlbmisc_o), .ea_o(ea_o), .ba_o(ba_o),
      .badaddr_o(badaddr_o), .pc_o(pc_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag, input logic exp_done, input logic exp_err);
      check({tag, " done"},    {31'd0, done_o}, {31'd0, exp_done});
      check({tag, " err"},     {31'd0, err_o},  {31'd0, exp_err});
      check({tag, " status"},  status_o,  m_st);
      check({tag, " estatus"}, estatus_o, m_est);
      check({tag, " bstatus"}, bstatus_o, m_bst);
      check({tag, " exc"},     exc_o,     m_ex);
      check({tag, " tlbmisc"}, tlbmisc_o, m_tm);
      check({tag, " ea"},      ea_o,      m_ea);
      check({tag, " ba"},      ba_o,      m_ba);
      check({tag, " badaddr"}, badaddr_o, m_bad);
      check({tag, " pc"},      pc_o,      m_pc);
   endtask

   // drive one strobe at a falling edge; outputs are sampled at the next falling edge
   task automatic fire(input logic [4:0] c, input logic [31:0] p, input logic [31:0] s,
                       input logic [31:0] t, input logic [31:0] e, input logic [31:0] f);
      @(negedge clk);
      cause = c; pc = p; st = s; tm = t; ex = e; fa = f; take = 1'b1;
      @(negedge clk);
      take = 1'b0;
   endtask

   function automatic logic [31:0] fld(input logic [31:0] e, input logic [4:0] c);
      return (e & ~FMSK) | ({27'd0, c} << 2);
   endfunction

   function automatic logic [31:0] entered(input logic [31:0] s);
      return (s & ~32'h3) | 32'h4;
   endfunction

   task automatic t_reset;
      m_st = '0; m_est = '0; m_bst = '0; m_ex = '0; m_tm = '0;
      m_ea = '0; m_ba = '0; m_bad = '0; m_pc = '0;
      compare_all("R12 reset", 1'b0, 1'b0);
   endtask

   task automatic t_irq;
      fire(5'd2, 32'h1000, 32'h0000_0021, 32'h0000_00F0, 32'hFFFF_FF83, 32'h0);
      m_est = 32'h21; m_ea = 32'h1004; m_st = 32'h28;
      m_ex = fld(32'hFFFF_FF83, 5'd2); m_tm = 32'hF0; m_pc = VGEN;
      compare_all("R1 R3 irq", 1'b1, 1'b0);
   endtask

   task automatic t_irq_masked;
      fire(5'd2, 32'h2000, 32'h0000_0002, 32'h5, 32'h0, 32'h0);
      compare_all("R2 masked irq", 1'b0, 1'b0);
   endtask

   task automatic t_miss_first;
      fire(5'd12, 32'h3000, 32'h0000_0003, 32'h0000_0101, 32'h8000_0000, 32'h0);
      m_est = 32'h3; m_ea = 32'h3004; m_st = 32'h4;
      m_tm = 32'h0000_0102; m_ex = fld(32'h8000_0000, 5'd12); m_pc = VTLB;
      compare_all("R4 R3 first miss", 1'b1, 1'b0);
   endtask

   task automatic t_miss_nested;
      fire(5'd12, 32'h4000, 32'h0000_0005, 32'h0000_0002, 32'h0, 32'h0);
      m_st = 32'h4; m_tm = 32'h3; m_ex = fld(32'h0, 5'd12); m_pc = VGEN;
      compare_all("R5 nested miss", 1'b1, 1'b0);
   endtask

   task automatic t_perm;
      fire(5'd16, 32'h5000, 32'h0000_0007, 32'h0000_0055, 32'h0000_0003, 32'h0);
      m_est = 32'h7; m_ea = 32'h5004; m_st = 32'h4; m_tm = 32'h55;
      m_ex = fld(32'h3, 5'd16); m_pc = VGEN;
      compare_all("R6 perm write", 1'b1, 1'b0);
   endtask

   task automatic t_soft;
      fire(5'd3, 32'h6000, 32'h0000_0013, 32'h0, 32'h0, 32'h0);
      m_est = 32'h13; m_ea = 32'h6004; m_st = entered(32'h13);
      m_tm = 32'h0; m_ex = fld(32'h0, 5'd3); m_pc = VGEN;
      compare_all("R7 trap eh clear", 1'b1, 1'b0);
      fire(5'd10, 32'h7000, 32'h0000_0006, 32'h0, 32'h0, 32'h0);
      m_st = entered(32'h6); m_ex = fld(32'h0, 5'd10);
      compare_all("R7 super eh set", 1'b1, 1'b0);
   endtask

   task automatic t_break;
      fire(5'd7, 32'h8000, 32'h0000_0001, 32'h0, 32'h0, 32'h0);
      m_bst = 32'h1; m_ba = 32'h8004; m_st = 32'h4; m_ex = fld(32'h0, 5'd7); m_pc = VGEN;
      compare_all("R8 break eh clear", 1'b1, 1'b0);
      fire(5'd7, 32'h9000, 32'h0000_0004, 32'h0, 32'h0, 32'h0);
      m_st = 32'h4;
      compare_all("R8 break eh set", 1'b1, 1'b0);
   endtask

   task automatic t_unalign;
      fire(5'd6, 32'hA000, 32'h0000_0001, 32'h0000_0009, 32'hFFFF_FFFF, 32'hDEAD_BEE1);
      m_bad = 32'hDEAD_BEE1; m_ex = 32'h18; m_st = 32'h1; m_tm = 32'h9; m_pc = VGEN;
      compare_all("R9 unaligned", 1'b1, 1'b0);
   endtask

   task automatic t_unknown;
      fire(5'd31, 32'hB000, 32'h0000_0001, 32'h0, 32'h0, 32'h0);
      compare_all("R10 unknown cause", 1'b0, 1'b1);
      fire(5'd13, 32'hB000, 32'h0000_0001, 32'h0, 32'h0, 32'h0);
      compare_all("R10 gap cause", 1'b0, 1'b1);
   endtask

   task automatic t_hold;
      @(negedge clk);
      cause = 5'd3; pc = 32'hC000; st = 32'h1; tm = 32'hF; ex = 32'hF; fa = 32'h1;
      @(negedge clk);
      @(negedge clk);
      compare_all("R11 idle hold", 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_irq;
      t_irq_masked;
      t_miss_first;
      t_miss_nested;
      t_perm;
      t_soft;
      t_break;
      t_unalign;
      t_unknown;
      t_hold;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule